// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block walks the linked list of extended capabilities kept in a 4 KB configuration space. The list always begins at byte offset 256. Each entry is a 32-bit header holding an identifier, a version and a pointer to the next entry. A host issues one command at a time. A find command locates the entry with a given identifier. An add command links a new entry into the list and makes its register range read-only.

The walker reaches configuration storage through a dword-wide port with separate read and write strobes. Read data comes back one cycle after the read strobe. A second port clears the write-enable and write-one-to-clear mask entries of a dword, one dword per cycle. Each result reports an offset, the offset of the entry before it, and an error flag. The result is valid when the done pulse arrives and is held until the next command completes.

Top module: `capchain_walker`

## Requirements
- R1: While reset is applied and after it is released, busy, done, err, both read and write strobes and the mask-clear strobe are low, and res_off and res_prev are zero.
- R2: A header dword has the identifier in bits 15:0, the version in bits 19:16 and the next byte offset in bits 31:20. The list starts at byte offset LIST_BASE (256). If the dword there is all zeros, the list is empty and a find returns res_off 0 and res_prev 0.
- R3: A find follows next pointers until it reaches a header whose identifier matches. It returns that header's offset in res_off and the offset of the header before it in res_prev (0 when the match is the first entry).
- R4: A find that reaches a header with next field 0 without a match returns res_off 0 and the offset of that last header in res_prev. Identifier 0 is reserved, so a find for 0 yields the tail of the list this way.
- R5: A next pointer that is about to be followed must lie between 256 and 4088 inclusive and have its two low bits at zero. Otherwise the command ends with err high and both results zero.
- R6: After HOP_LIMIT pointer follows, a walk that still needs another follow ends with err high, so a circular list cannot hang the block.
- R7: An add at offset 256 reads the header there and rewrites it with the new identifier and version. The existing next field is kept, and res_prev is 0.
- R8: An add at any other offset walks to the tail of the list. It rewrites the tail's next field to the new offset and keeps the tail's bits 19:0. It then writes the new header with a next field of 0, and reports the tail in res_prev. An add on an empty list, or an add whose walk meets a header with identifier 0, ends with err.
- R9: An add ends with err and makes no write of any kind if its size is below 8, its offset plus size reaches 4096, its offset is below 256, or its offset is not dword aligned.
- R10: A successful add clears the mask entries of ceil(size/4) consecutive dwords, starting at dword offset/4, one dword per cycle at rising addresses.
- R11: A command is accepted only while busy is low. busy rises in the cycle after acceptance and stays high through the one-cycle done pulse. A command presented while busy has no effect.
- R12: Counting cycles from acceptance, done falls in cycle N. Here k is the number of headers read and d is ceil(size/4). N is 2 for a rejected add and 2+2k for a find or a walk error. N is 5+d for a head add and 4+2k+d for a tail add. Reads and writes never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_add | input | 1 | 1 = add, 0 = find |
| cmd_id | input | 16 | Identifier to find or to add |
| cmd_ver | input | 4 | Version for add |
| cmd_off | input | 12 | Byte offset for add |
| cmd_size | input | 13 | Byte size for add |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag of the last command |
| res_off | output | 12 | Found or added offset |
| res_prev | output | 12 | Previous entry offset |
| cfg_rd_en | output | 1 | Configuration read strobe |
| cfg_wr_en | output | 1 | Configuration write strobe |
| cfg_addr | output | 10 | Configuration dword address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rdata | input | 32 | Read data, one cycle after the read strobe |
| msk_clr_en | output | 1 | Mask clear strobe for both mask stores |
| msk_clr_addr | output | 10 | Dword address to clear |

## Verification
The bench builds the walker with LIST_BASE at 256 and HOP_LIMIT lowered to 8. With that limit, a deliberately circular list hits the hop guard after a few dozen cycles instead of thousands. A positive add ending at byte 4095 and rejected adds ending at 4096, at offset 0xC0 and at a misaligned offset test the range limits. Corrupted next pointers just below 256, above 4088 and misaligned are planted directly in the bench memory.

// File: rtl/capchain_pkg.sv
package capchain_pkg;
  localparam int OFF_W   = 12;
  localparam int CFG_BYTES = 1 << OFF_W;
  localparam int DA_W    = OFF_W - 2;
  localparam int ID_W    = 16;
  localparam int VER_W   = 4;
  localparam int MIN_CAP = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHK, ST_RD, ST_EVAL, ST_WR_TAIL, ST_WR_NEW, ST_SWEEP, ST_FIN
  } walk_st_t;

  typedef struct packed {
    logic [OFF_W-1:0] nxt;
    logic [VER_W-1:0] ver;
    logic [ID_W-1:0]  id;
  } cap_hdr_t;
endpackage

// File: rtl/capchain_ptr_check.sv
module capchain_ptr_check
  import capchain_pkg::*;
#(
  parameter int LIST_BASE = 256
) (
  input  logic [OFF_W-1:0] ptr,
  output logic             ok
);
  localparam logic [OFF_W-1:0] LO = OFF_W'(LIST_BASE);
  localparam logic [OFF_W-1:0] HI = OFF_W'(CFG_BYTES - MIN_CAP);

  always_comb begin
    ok = (ptr >= LO) && (ptr <= HI) && (ptr[1:0] == 2'b00);
  end
endmodule

// File: rtl/capchain_hop_guard.sv
module capchain_hop_guard #(
  parameter int HOP_LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic at_limit
);
  localparam int CW = $clog2(HOP_LIMIT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOP_LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (step && (cnt_q != LIMIT))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign at_limit = (cnt_q == LIMIT);
endmodule

// File: rtl/capchain_mask_sweep.sv
module capchain_mask_sweep
  import capchain_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DA_W-1:0] base,
  input  logic [DA_W:0]   count,
  output logic            we,
  output logic [DA_W-1:0] addr,
  output logic            last
);
  logic [DA_W:0]   left_q, left_d;
  logic [DA_W-1:0] addr_q, addr_d;

  always_comb begin
    left_d = left_q;
    addr_d = addr_q;
    if (start) begin
      left_d = count;
      addr_d = base;
    end else if (left_q != '0) begin
      left_d = left_q - 1'b1;
      addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      addr_q <= '0;
    end else begin
      left_q <= left_d;
      addr_q <= addr_d;
    end
  end

  assign we   = (left_q != '0);
  assign addr = addr_q;
  assign last = (left_q == {{DA_W{1'b0}}, 1'b1});
endmodule

// File: rtl/capchain_walker.sv
module capchain_walker
  import capchain_pkg::*;
#(
  parameter int LIST_BASE = 256,
  parameter int HOP_LIMIT = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_add,
  input  logic [15:0]      cmd_id,
  input  logic [3:0]       cmd_ver,
  input  logic [11:0]      cmd_off,
  input  logic [12:0]      cmd_size,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [11:0]      res_off,
  output logic [11:0]      res_prev,
  output logic             cfg_rd_en,
  output logic             cfg_wr_en,
  output logic [9:0]       cfg_addr,
  output logic [31:0]      cfg_wdata,
  input  logic [31:0]      cfg_rdata,
  output logic             msk_clr_en,
  output logic [9:0]       msk_clr_addr
);
  localparam logic [OFF_W-1:0] BASE_OFF  = OFF_W'(LIST_BASE);
  localparam logic [OFF_W+1:0] SPACE_END = (OFF_W+2)'(CFG_BYTES);
  localparam logic [OFF_W:0]   MIN_SIZE  = (OFF_W+1)'(MIN_CAP);

  walk_st_t state_q, state_d;
  logic [OFF_W-1:0] cur_q, cur_d, prev_q, prev_d;
  logic [OFF_W-1:0] off_q, off_d, nnext_q, nnext_d;
  logic [OFF_W-1:0] res_off_q, res_off_d, res_prev_q, res_prev_d;
  logic [OFF_W:0]   size_q, size_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic [VER_W-1:0] ver_q, ver_d;
  logic [19:0]      hdr_lo_q, hdr_lo_d;
  logic add_q, add_d, head_q, head_d, first_q, first_d, err_q, err_d;

  logic             hop_clr, hop_step, hop_limit;
  logic             sweep_start, sweep_last;
  logic             nx_ok, add_bad;
  logic [OFF_W+1:0] end_sum;
  logic [DA_W:0]    sweep_cnt;
  logic [ID_W-1:0]  srch_id;
  cap_hdr_t         rhdr;

  assign rhdr      = cap_hdr_t'(cfg_rdata);
  assign srch_id   = add_q ? '0 : id_q;
  assign end_sum   = {2'b00, off_q} + {1'b0, size_q};
  assign add_bad   = (size_q < MIN_SIZE) || (end_sum >= SPACE_END) ||
                     (off_q < BASE_OFF) || (off_q[1:0] != 2'b00);
  assign sweep_cnt = size_q[OFF_W:2] + {{DA_W{1'b0}}, |size_q[1:0]};

  capchain_ptr_check #(.LIST_BASE(LIST_BASE)) ptr_chk_i (
    .ptr (rhdr.nxt),
    .ok  (nx_ok)
  );

  capchain_hop_guard #(.HOP_LIMIT(HOP_LIMIT)) hop_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (hop_clr),
    .step     (hop_step),
    .at_limit (hop_limit)
  );

  capchain_mask_sweep sweep_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sweep_start),
    .base  (off_q[OFF_W-1:2]),
    .count (sweep_cnt),
    .we    (msk_clr_en),
    .addr  (msk_clr_addr),
    .last  (sweep_last)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;  cur_d = cur_q;   prev_d = prev_q;
    off_d   = off_q;    nnext_d = nnext_q; size_d = size_q;
    id_d    = id_q;     ver_d = ver_q;   hdr_lo_d = hdr_lo_q;
    add_d   = add_q;    head_d = head_q; first_d = first_q;
    err_d   = err_q;    res_off_d = res_off_q; res_prev_d = res_prev_q;
    hop_clr = 1'b0;     hop_step = 1'b0; sweep_start = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          add_d  = cmd_add;  id_d   = cmd_id;   ver_d = cmd_ver;
          off_d  = cmd_off;  size_d = cmd_size; err_d = 1'b0;
          state_d = ST_CHK;
        end
      end
      ST_CHK: begin
        cur_d   = BASE_OFF;
        prev_d  = '0;
        first_d = 1'b1;
        hop_clr = 1'b1;
        head_d  = add_q && (off_q == BASE_OFF);
        if (add_q && add_bad) begin
          err_d = 1'b1; res_off_d = '0; res_prev_d = '0;
          state_d = ST_FIN;
        end else begin
          state_d = ST_RD;
        end
      end
      ST_RD: state_d = ST_EVAL;
      ST_EVAL: begin
        if (add_q && head_q) begin
          nnext_d = rhdr.nxt;
          state_d = ST_WR_NEW;
        end else if (first_q && (cfg_rdata == '0)) begin
          err_d = add_q; res_off_d = '0; res_prev_d = '0;
          state_d = ST_FIN;
        end else if (rhdr.id == srch_id) begin
          err_d      = add_q;
          res_off_d  = add_q ? '0 : cur_q;
          res_prev_d = add_q ? '0 : prev_q;
          state_d    = ST_FIN;
        end else if (rhdr.nxt == '0) begin
          if (add_q) begin
            hdr_lo_d = cfg_rdata[19:0];
            state_d  = ST_WR_TAIL;
          end else begin
            res_off_d = '0; res_prev_d = cur_q;
            state_d = ST_FIN;
          end
        end else if (!nx_ok || hop_limit) begin
          err_d = 1'b1; res_off_d = '0; res_prev_d = '0;
          state_d = ST_FIN;
        end else begin
          hop_step = 1'b1;
          prev_d   = cur_q;
          cur_d    = rhdr.nxt;
          first_d  = 1'b0;
          state_d  = ST_RD;
        end
      end
      ST_WR_TAIL: begin
        prev_d  = cur_q;
        nnext_d = '0;
        state_d = ST_WR_NEW;
      end
      ST_WR_NEW: begin
        sweep_start = 1'b1;
        state_d = ST_SWEEP;
      end
      ST_SWEEP: begin
        if (sweep_last) begin
          res_off_d = off_q; res_prev_d = prev_q;
          state_d = ST_FIN;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  cur_q <= '0;   prev_q <= '0;
      off_q   <= '0;       nnext_q <= '0; size_q <= '0;
      id_q    <= '0;       ver_q <= '0;   hdr_lo_q <= '0;
      add_q   <= 1'b0;     head_q <= 1'b0; first_q <= 1'b0;
      err_q   <= 1'b0;     res_off_q <= '0; res_prev_q <= '0;
    end else begin
      state_q <= state_d;  cur_q <= cur_d; prev_q <= prev_d;
      off_q   <= off_d;    nnext_q <= nnext_d; size_q <= size_d;
      id_q    <= id_d;     ver_q <= ver_d; hdr_lo_q <= hdr_lo_d;
      add_q   <= add_d;    head_q <= head_d; first_q <= first_d;
      err_q   <= err_d;    res_off_q <= res_off_d; res_prev_q <= res_prev_d;
    end
  end

  // port decode
  always_comb begin
    cfg_addr  = cur_q[OFF_W-1:2];
    cfg_wdata = {off_q, hdr_lo_q};
    if (state_q == ST_WR_NEW) begin
      cfg_addr  = off_q[OFF_W-1:2];
      cfg_wdata = {nnext_q, ver_q, id_q};
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign err       = err_q;
  assign res_off   = res_off_q;
  assign res_prev  = res_prev_q;
  assign cfg_rd_en = (state_q == ST_RD);
  assign cfg_wr_en = (state_q == ST_WR_TAIL) || (state_q == ST_WR_NEW);
endmodule

// File: rtl/capchain_walker_chk.sv
module capchain_walker_chk #(
  parameter int LIST_BASE = 256
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        cfg_rd_en,
  input logic        cfg_wr_en,
  input logic [9:0]  cfg_addr,
  input logic        msk_clr_en,
  input logic [9:0]  msk_clr_addr,
  input logic [11:0] res_off,
  input logic [11:0] res_prev
);
  localparam logic [9:0] FLOOR = 10'(LIST_BASE / 4);

  a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(cfg_rd_en || cfg_wr_en || msk_clr_en));

  a_r12_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_rd_en && cfg_wr_en));

  a_r8_write_floor: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |-> (cfg_addr >= FLOOR));

  a_r10_clear_floor: assert property (@(posedge clk) disable iff (!rst_n)
    msk_clr_en |-> (msk_clr_addr >= FLOOR));

  a_r10_clear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_clr_en && $past(msk_clr_en)) |-> (msk_clr_addr == 10'($past(msk_clr_addr) + 1'b1)));

  a_r11_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> ($stable(res_off) && $stable(res_prev)));
endmodule

bind capchain_walker capchain_walker_chk #(.LIST_BASE(LIST_BASE)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .cfg_rd_en    (cfg_rd_en),
  .cfg_wr_en    (cfg_wr_en),
  .cfg_addr     (cfg_addr),
  .msk_clr_en   (msk_clr_en),
  .msk_clr_addr (msk_clr_addr),
  .res_off      (res_off),
  .res_prev     (res_prev)
);

// File: tb/capchain_walker_tb_top.sv
module capchain_walker_tb_top;
  localparam int HL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_add = 1'b0;
  logic [15:0] cmd_id = '0;
  logic [3:0]  cmd_ver = '0;
  logic [11:0] cmd_off = '0;
  logic [12:0] cmd_size = '0;
  logic busy, done, err, cfg_rd_en, cfg_wr_en, msk_clr_en;
  logic [11:0] res_off, res_prev;
  logic [9:0]  cfg_addr, msk_clr_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata = '0;

  logic [31:0] mem [1024];
  logic        msk [1024];
  logic [31:0] ref_mem [1024];
  logic        ref_msk [1024];

  logic        tb_wr = 1'b0, tb_clear = 1'b0;
  logic [9:0]  tb_wa = '0;
  logic [31:0] tb_wd = '0;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  capchain_walker #(.LIST_BASE(256), .HOP_LIMIT(HL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_add(cmd_add),
    .cmd_id(cmd_id), .cmd_ver(cmd_ver), .cmd_off(cmd_off), .cmd_size(cmd_size),
    .busy(busy), .done(done), .err(err), .res_off(res_off), .res_prev(res_prev),
    .cfg_rd_en(cfg_rd_en), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .msk_clr_en(msk_clr_en), .msk_clr_addr(msk_clr_addr)
  );

  // configuration and mask storage
  always @(posedge clk) begin
    if (tb_clear) begin
      for (int i = 0; i < 1024; i++) begin
        mem[i] <= '0;
        msk[i] <= 1'b1;
      end
    end else begin
      if (cfg_rd_en) cfg_rdata <= mem[cfg_addr];
      if (cfg_wr_en) mem[cfg_addr] <= cfg_wdata;
      if (tb_wr) mem[tb_wa] <= tb_wd;
      if (msk_clr_en) msk[msk_clr_addr] <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic poke(input int byte_off, input logic [31:0] v);
    @(negedge clk); tb_wr = 1'b1; tb_wa = 10'(byte_off / 4); tb_wd = v;
    @(negedge clk); tb_wr = 1'b0;
  endtask

  task automatic wipe();
    @(negedge clk); tb_clear = 1'b1;
    @(negedge clk); tb_clear = 1'b0;
  endtask

  function automatic logic [31:0] hdr(input int nx, input int ver, input int id);
    return {12'(nx), 4'(ver), 16'(id)};
  endfunction

  // behavioural reference: expected results, cycle count and storage effects
  task automatic model(input bit add, input int id, input int ver, input int off,
                       input int size, output int eo, output int ep, output int ee,
                       output int en);
    int d, cur, prv, k, hops, srch, nx;
    bit first;
    logic [31:0] h;
    for (int i = 0; i < 1024; i++) begin
      ref_mem[i] = mem[i];
      ref_msk[i] = msk[i];
    end
    eo = 0; ep = 0; ee = 0;
    d = (size + 3) / 4;
    if (add && (size < 8 || off + size >= 4096 || off < 256 || (off % 4) != 0)) begin
      ee = 1; en = 2; return;
    end
    if (add && off == 256) begin
      h = mem[64];
      ref_mem[64] = {h[31:20], 4'(ver), 16'(id)};
      for (int i = 0; i < d; i++) ref_msk[64 + i] = 1'b0;
      eo = 256; en = 5 + d; return;
    end
    srch = add ? 0 : id;
    cur = 256; prv = 0; k = 1; hops = 0; first = 1'b1; h = mem[64];
    forever begin
      nx = int'(h[31:20]);
      if (first && h == '0) begin
        ee = add; en = 2 + 2 * k; return;
      end
      if (int'(h[15:0]) == srch) begin
        ee = add;
        if (!add) begin eo = cur; ep = prv; end
        en = 2 + 2 * k; return;
      end
      if (nx == 0) begin
        if (add) begin
          ref_mem[cur / 4] = {12'(off), h[19:0]};
          ref_mem[off / 4] = hdr(0, ver, id);
          for (int i = 0; i < d; i++) ref_msk[off / 4 + i] = 1'b0;
          eo = off; ep = cur; en = 4 + 2 * k + d;
        end else begin
          ep = cur; en = 2 + 2 * k;
        end
        return;
      end
      if (nx < 256 || nx > 4088 || (nx % 4) != 0 || hops == HL) begin
        ee = 1; en = 2 + 2 * k; return;
      end
      hops++; prv = cur; cur = nx; first = 1'b0; k++;
      h = mem[cur / 4];
    end
  endtask

  task automatic do_cmd(input bit add, input int id, input int ver, input int off,
                        input int size, input bit hold_poke, input string tag);
    int eo, ep, ee, en, bad_cyc, mism;
    model(add, id, ver, off, size, eo, ep, ee, en);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_add = add; cmd_id = 16'(id); cmd_ver = 4'(ver);
    cmd_off = 12'(off); cmd_size = 13'(size);
    bad_cyc = 0;
    for (int c = 1; c <= en; c++) begin
      @(negedge clk);
      if (hold_poke && c < en - 1) begin
        cmd_valid = 1'b1; cmd_add = 1'b1; cmd_id = 16'hBEEF;
        cmd_off = 12'h300; cmd_size = 13'd8;
      end else begin
        cmd_valid = 1'b0;
      end
      if (busy !== 1'b1 || done !== (c == en)) bad_cyc = c;
    end
    @(negedge clk);
    if (busy !== 1'b0 || done !== 1'b0) bad_cyc = en + 1;
    chk(bad_cyc == 0, {tag, " R12 R11 busy/done timing, cycle"}, bad_cyc, 0);
    chk(err === ee[0], {tag, " err"}, int'(err), ee);
    chk(res_off === 12'(eo), {tag, " res_off"}, int'(res_off), eo);
    chk(res_prev === 12'(ep), {tag, " res_prev"}, int'(res_prev), ep);
    mism = 0;
    for (int i = 0; i < 1024; i++)
      if (mem[i] !== ref_mem[i] || msk[i] !== ref_msk[i]) mism++;
    chk(mism == 0, {tag, " storage mismatches"}, mism, 0);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired R11 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int idle_bad;
    repeat (3) @(negedge clk);
    // R1: reset state while held
    chk({busy, done, err, cfg_rd_en, cfg_wr_en, msk_clr_en} == 6'b0 &&
        res_off == '0 && res_prev == '0, "R1 reset outputs",
        int'({busy, done, err, cfg_rd_en, cfg_wr_en, msk_clr_en}), 0);
    rst_n = 1'b1;
    wipe();
    chk({busy, done, err, cfg_rd_en, cfg_wr_en, msk_clr_en} == 6'b0,
        "R1 after release", int'({busy, done, err}), 0);

    // R2 empty list, R4 reserved id on empty list
    do_cmd(1'b0, 16'h0010, 0, 0, 0, 1'b0, "R2 find on empty");
    do_cmd(1'b0, 0, 0, 0, 0, 1'b0, "R4 find id0 on empty");
    // R8 tail add on empty list errors
    do_cmd(1'b1, 16'h000B, 2, 12'h180, 8, 1'b0, "R8 add on empty");
    // R7 R10 head add on empty list
    do_cmd(1'b1, 16'h0001, 1, 256, 12, 1'b0, "R7 R10 head add");
    // R8 R10 tail adds
    do_cmd(1'b1, 16'h000B, 2, 12'h180, 16, 1'b0, "R8 R10 add 0x180");
    do_cmd(1'b1, 16'h0003, 1, 12'h200, 10, 1'b0, "R8 R10 add 0x200");
    // R3 matches
    do_cmd(1'b0, 16'h000B, 0, 0, 0, 1'b0, "R3 find middle");
    do_cmd(1'b0, 16'h0001, 0, 0, 0, 1'b0, "R3 find head");
    do_cmd(1'b0, 16'h0003, 0, 0, 0, 1'b0, "R3 find last");
    // R4 miss and reserved id
    do_cmd(1'b0, 16'h0099, 0, 0, 0, 1'b0, "R4 find miss");
    do_cmd(1'b0, 0, 0, 0, 0, 1'b0, "R4 find id0 tail");
    // R9 rejected adds
    do_cmd(1'b1, 16'h0040, 1, 12'h300, 4, 1'b0, "R9 size below 8");
    do_cmd(1'b1, 16'h0040, 1, 12'hFF8, 8, 1'b0, "R9 end at 4096");
    do_cmd(1'b1, 16'h0040, 1, 12'h0C0, 8, 1'b0, "R9 offset below base");
    do_cmd(1'b1, 16'h0040, 1, 12'h302, 8, 1'b0, "R9 misaligned offset");
    do_cmd(1'b1, 16'h0040, 1, 12'hFF8, 7, 1'b0, "R9 size 7");
    // R8 R9 boundary: ends at byte 4095
    do_cmd(1'b1, 16'h0044, 1, 12'hFF4, 11, 1'b0, "R8 R9 add ending at 4095");
    // R7 head add keeps next pointer
    do_cmd(1'b1, 16'h0020, 3, 256, 8, 1'b0, "R7 head add keeps next");
    do_cmd(1'b0, 16'h0044, 0, 0, 0, 1'b0, "R3 find after head rewrite");
    // R5 corrupted pointers
    poke(12'hFF4, hdr(12'h0FC, 1, 16'h0044));
    do_cmd(1'b0, 16'h0077, 0, 0, 0, 1'b0, "R5 next below base");
    poke(12'hFF4, hdr(12'hFFC, 1, 16'h0044));
    do_cmd(1'b0, 16'h0077, 0, 0, 0, 1'b0, "R5 next above 4088");
    poke(12'hFF4, hdr(12'h182, 1, 16'h0044));
    do_cmd(1'b0, 16'h0077, 0, 0, 0, 1'b0, "R5 next misaligned");
    // R6 circular list
    poke(12'hFF4, hdr(12'h180, 1, 16'h0044));
    do_cmd(1'b0, 16'h0077, 0, 0, 0, 1'b0, "R6 circular list");
    do_cmd(1'b1, 16'h0050, 1, 12'h400, 8, 1'b0, "R6 R8 add on circular list");
    do_cmd(1'b0, 16'h0003, 0, 0, 0, 1'b0, "R3 R6 find within loop");
    poke(12'hFF4, hdr(0, 1, 16'h0044));
    // R11 commands while busy are ignored
    do_cmd(1'b0, 16'h0003, 0, 0, 0, 1'b1, "R11 find with requests while busy");
    idle_bad = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (busy !== 1'b0 || cfg_wr_en !== 1'b0 || msk_clr_en !== 1'b0) idle_bad++;
    end
    chk(idle_bad == 0, "R11 no command started after busy requests", idle_bad, 0);
    chk(mem[12'h300 / 4] === 32'h0 && msk[12'h300 / 4] === 1'b1,
        "R11 ignored add left storage untouched", int'(mem[12'h300 / 4]), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule